// File: doc/BRIEF.md
# Two-Wire Bus Address Slave with Group Decode

This block is the receiving front end of a slave on an open-drain two-wire bus. It takes the serial clock and data lines, already brought into the system clock domain, and finds the START condition. After a START it collects the seven address bits and the direction bit that follow. It then compares the address against its own. That own address is split into a group prefix and a member selector. Up to eight identical devices can therefore share one prefix, each set to a different selector.

When the address is its own, the block pulls the data line low for the acknowledge clock. In the same cycle that the pull begins, it raises a one-cycle match strobe and updates the direction flag. Without a match it keeps its hands off the bus until the next START. A STOP returns it to idle at any time, and a repeated START restarts address collection at any point. Data bytes after the address, long addresses and clock stretching are handled elsewhere.

Top module: `bus_addr_slave`

## Requirements
- R1: While reset is held and after it is released, `sda_pull`, `match_pulse` and `dir_read` are 0.
- R2: Address reception begins only when SDA falls while SCL stays high. Bits clocked without such a START are not collected.
- R3: The address is taken at SCL rising edges, most significant bit first. Its value is compared against `{grp_prefix, member_id}`, with the prefix in the upper four bits and the member in the lower three.
- R4: The eighth bit sets the direction, where 1 means read and 0 means write. `dir_read` takes this value only when the address matches, and otherwise keeps its last value.
- R5: On a match, `sda_pull` rises one clock after the SCL falling edge that ends the eighth bit. It drops one clock after the SCL falling edge that ends the ninth (acknowledge) clock.
- R6: On a mismatch, `sda_pull` stays 0 through the acknowledge clock, so the master sees SDA high.
- R7: `match_pulse` is high for exactly one clock per matching address, in the first cycle of `sda_pull`.
- R8: A STOP (SDA rising while SCL is high) returns the block to idle at once and releases `sda_pull`.
- R9: A repeated START in the middle of an address discards the bits collected so far and restarts reception.
- R10: Changing either field of the own address changes which address is acknowledged. An address that differs only in the three member bits is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronized serial clock line level |
| sda_in | input | 1 | Synchronized serial data line level |
| grp_prefix | input | 4 | Group prefix of the own address (upper bits) |
| member_id | input | 3 | Member selector within the group (lower bits) |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| match_pulse | output | 1 | One-cycle strobe on an address match |
| dir_read | output | 1 | Direction of the last matched address, 1 = read |

## Verification
The hardest situations to reach from the ports are the broken frames. These are a STOP that lands partway through the address and a repeated START after a few wrong bits. After either one, the very next bits must be judged from a clean start. The stimulus builds these frames from the same bit-level tasks as normal transfers. After a mid-address STOP it clocks a full matching address with no START, and that address must draw no acknowledge. The stimulus also sends the bit-reversed form of a valid address and an address differing only in the member field. A per-clock behavioural model watches the wired-AND data line and checks that the pull starts and ends on the correct SCL edges.

// File: rtl/busslv_pkg.sv
package busslv_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_ACK  = 2'd2,
    PH_SKIP = 2'd3
  } phase_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } line_evt_t;

endpackage

// File: rtl/line_watch.sv
module line_watch
  import busslv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      scl_in,
  input  logic      sda_in,
  output line_evt_t evt
);

  logic scl_q;
  logic sda_q;

  // idle bus level is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  always_comb begin
    evt.start = scl_q & scl_in & sda_q & ~sda_in;
    evt.stop  = scl_q & scl_in & ~sda_q & sda_in;
    evt.rise  = ~scl_q & scl_in;
    evt.fall  = scl_q & ~scl_in;
  end

endmodule

// File: rtl/addr_shift.sv
module addr_shift #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               shift_en,
  input  logic               sda_in,
  output logic [FRAME_W-1:0] frame,
  output logic               full
);

  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [CNT_W-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame   <= '0;
      bit_cnt <= '0;
    end else if (clear) begin
      frame   <= '0;
      bit_cnt <= '0;
    end else if (shift_en && !full) begin
      frame   <= {frame[FRAME_W-2:0], sda_in};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign full = (bit_cnt == CNT_FULL);

  // R3: never more bits collected than a frame holds
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_FULL);

  // R9: a restart empties the collector on the next cycle
  p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (bit_cnt == '0));

endmodule

// File: rtl/ack_ctrl.sv
module ack_ctrl
  import busslv_pkg::*;
#(
  parameter int PREFIX_W = 4,
  parameter int MEMBER_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  line_evt_t                    evt,
  input  logic [PREFIX_W+MEMBER_W:0]   frame,
  input  logic                         full,
  input  logic [PREFIX_W-1:0]          grp_prefix,
  input  logic [MEMBER_W-1:0]          member_id,
  output logic                         shift_clr,
  output logic                         shift_en,
  output logic                         sda_pull,
  output logic                         match_pulse,
  output logic                         dir_read
);

  localparam int ADDR_W  = PREFIX_W + MEMBER_W;
  localparam int FRAME_W = ADDR_W + 1;

  phase_t phase;
  logic   addr_hit;
  logic   decide;

  function automatic logic own_addr(input logic [FRAME_W-1:0] f,
                                    input logic [PREFIX_W-1:0] pfx,
                                    input logic [MEMBER_W-1:0] mem);
    return f[FRAME_W-1:1] == {pfx, mem};
  endfunction

  assign addr_hit  = own_addr(frame, grp_prefix, member_id);
  assign decide    = (phase == PH_ADDR) && evt.fall && full;
  assign shift_clr = evt.start;
  assign shift_en  = (phase == PH_ADDR) && evt.rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      sda_pull    <= 1'b0;
      match_pulse <= 1'b0;
      dir_read    <= 1'b0;
    end else begin
      match_pulse <= 1'b0;
      if (evt.start) begin
        phase    <= PH_ADDR;
        sda_pull <= 1'b0;
      end else if (evt.stop) begin
        phase    <= PH_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (phase)
          PH_ADDR: begin
            if (decide) begin
              if (addr_hit) begin
                phase       <= PH_ACK;
                sda_pull    <= 1'b1;
                match_pulse <= 1'b1;
                dir_read    <= frame[0];
              end else begin
                phase <= PH_SKIP;
              end
            end
          end
          PH_ACK: begin
            if (evt.fall) begin
              sda_pull <= 1'b0;
              phase    <= PH_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7: strobe lasts one cycle
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);

  // R7: strobe coincides with the acknowledge pull
  p_pulse_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> sda_pull);

  // R5: pull only begins right after an SCL falling edge
  p_onset_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(evt.fall));

  // R5: acknowledge clock ending releases the line
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACK && evt.fall) |=> !sda_pull);

  // R6: no pull outside the acknowledge phase
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE || phase == PH_SKIP) |-> !sda_pull);

  // R8: stop returns to idle
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt.stop |=> (phase == PH_IDLE && !sda_pull));

  // R9: any start restarts address reception
  p_start_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt.start |=> (phase == PH_ADDR && !sda_pull));

endmodule

// File: rtl/bus_addr_slave.sv
module bus_addr_slave
  import busslv_pkg::*;
#(
  parameter int PREFIX_W = 4,
  parameter int MEMBER_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_in,
  input  logic                sda_in,
  input  logic [PREFIX_W-1:0] grp_prefix,
  input  logic [MEMBER_W-1:0] member_id,
  output logic                sda_pull,
  output logic                match_pulse,
  output logic                dir_read
);

  localparam int FRAME_W = PREFIX_W + MEMBER_W + 1;

  line_evt_t          evt;
  logic [FRAME_W-1:0] frame;
  logic               full;
  logic               shift_clr;
  logic               shift_en;

  line_watch u_watch (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_in (scl_in),
    .sda_in (sda_in),
    .evt    (evt)
  );

  addr_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (shift_clr),
    .shift_en (shift_en),
    .sda_in   (sda_in),
    .frame    (frame),
    .full     (full)
  );

  ack_ctrl #(.PREFIX_W(PREFIX_W), .MEMBER_W(MEMBER_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt         (evt),
    .frame       (frame),
    .full        (full),
    .grp_prefix  (grp_prefix),
    .member_id   (member_id),
    .shift_clr   (shift_clr),
    .shift_en    (shift_en),
    .sda_pull    (sda_pull),
    .match_pulse (match_pulse),
    .dir_read    (dir_read)
  );

endmodule

// File: tb/tb_bus_addr_slave.sv
module tb_bus_addr_slave;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [3:0] grp_prefix = 4'b1010;
  logic [2:0] member_id = 3'b011;
  logic       sda_pull;
  logic       match_pulse;
  logic       dir_read;
  logic       sda_bus;

  int errors = 0;
  int checks = 0;
  int pulse_cnt = 0;
  logic ack_seen;
  logic done = 1'b0;

  assign sda_bus = sda_m & ~sda_pull;

  always #(CLK_P/2) clk = ~clk;

  bus_addr_slave dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_in      (scl_m),
    .sda_in      (sda_bus),
    .grp_prefix  (grp_prefix),
    .member_id   (member_id),
    .sda_pull    (sda_pull),
    .match_pulse (match_pulse),
    .dir_read    (dir_read)
  );

  task automatic check(input logic cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 collecting, 2 acknowledging, 3 waiting
  int   m_ph = 0;
  int   m_cnt = 0;
  int   m_val = 0;
  logic m_pscl = 1'b1;
  logic m_psda = 1'b1;
  logic exp_pull = 1'b0;
  logic exp_pulse = 1'b0;
  logic exp_dir = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph <= 0; m_cnt <= 0; m_val <= 0;
      m_pscl <= 1'b1; m_psda <= 1'b1;
      exp_pull <= 1'b0; exp_pulse <= 1'b0; exp_dir <= 1'b0;
    end else begin
      m_pscl <= scl_m;
      m_psda <= sda_bus;
      exp_pulse <= 1'b0;
      if (m_pscl && scl_m && m_psda && !sda_bus) begin
        m_ph <= 1; m_cnt <= 0; m_val <= 0; exp_pull <= 1'b0;
      end else if (m_pscl && scl_m && !m_psda && sda_bus) begin
        m_ph <= 0; exp_pull <= 1'b0;
      end else if (m_ph == 1) begin
        if (!m_pscl && scl_m && m_cnt < 8) begin
          m_val <= m_val * 2 + int'(sda_bus);
          m_cnt <= m_cnt + 1;
        end else if (m_pscl && !scl_m && m_cnt == 8) begin
          if (m_val / 2 == int'(grp_prefix) * 8 + int'(member_id)) begin
            m_ph <= 2; exp_pull <= 1'b1; exp_pulse <= 1'b1;
            exp_dir <= (m_val % 2) == 1;
          end else begin
            m_ph <= 3;
          end
        end
      end else if (m_ph == 2) begin
        if (m_pscl && !scl_m) begin
          exp_pull <= 1'b0; m_ph <= 3;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (match_pulse) pulse_cnt++;
    if (rst_n && !done) begin
      check(sda_pull == exp_pull, "R5 pull per-cycle", int'(sda_pull), int'(exp_pull));
      check(match_pulse == exp_pulse, "R7 pulse per-cycle", int'(match_pulse), int'(exp_pulse));
      check(dir_read == exp_dir, "R4 dir per-cycle", int'(dir_read), int'(exp_dir));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(2);
    scl_m = 1'b1; tick(4);
    sda_m = 1'b0; tick(4);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(2);
    scl_m = 1'b1; tick(4);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic ack_clock();
    sda_m = 1'b1; tick(2);
    scl_m = 1'b1; tick(2);
    ack_seen = ~sda_bus;
    tick(2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(2);
    scl_m = 1'b1; tick(4);
    sda_m = 1'b1; tick(4);
  endtask

  task automatic send_addr(input logic [6:0] a);
    for (int i = 6; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic xfer(input logic [6:0] a, input logic rw, input logic hit, input string tag);
    int p0;
    bus_start();
    send_addr(a);
    p0 = pulse_cnt;
    send_bit(rw);
    ack_clock();
    check(ack_seen == hit, tag, int'(ack_seen), int'(hit));
    check((pulse_cnt - p0) == (hit ? 1 : 0), "R7 one strobe per match", pulse_cnt - p0, hit ? 1 : 0);
    check(sda_pull == 1'b0, "R5 released after ack clock", int'(sda_pull), 0);
    bus_stop();
  endtask

  initial begin
    tick(3);
    check(sda_pull == 1'b0, "R1 reset pull", int'(sda_pull), 0);
    check(match_pulse == 1'b0, "R1 reset strobe", int'(match_pulse), 0);
    check(dir_read == 1'b0, "R1 reset dir", int'(dir_read), 0);
    rst_n = 1'b1;
    tick(4);

    // R3: own address 1010_011 written MSB first
    xfer(7'b1010011, 1'b0, 1'b1, "R3 write to own address");
    check(dir_read == 1'b0, "R4 write direction", int'(dir_read), 0);
    xfer(7'b1010011, 1'b1, 1'b1, "R3 read from own address");
    check(dir_read == 1'b1, "R4 read direction", int'(dir_read), 1);

    // R6: neighbour member, no acknowledge, direction kept
    xfer(7'b1010010, 1'b0, 1'b0, "R6 neighbour member ignored");
    check(dir_read == 1'b1, "R4 dir kept on miss", int'(dir_read), 1);

    // R3: bit-reversed own address must miss
    xfer(7'b1100101, 1'b0, 1'b0, "R3 reversed order missed");

    // R10: reconfigure the member and then the prefix
    member_id = 3'b101; tick(2);
    xfer(7'b1010101, 1'b0, 1'b1, "R10 new member acknowledged");
    xfer(7'b1010011, 1'b0, 1'b0, "R10 old member now ignored");
    xfer(7'b0010101, 1'b1, 1'b0, "R10 wrong prefix ignored");
    grp_prefix = 4'b0010; tick(2);
    xfer(7'b0010101, 1'b1, 1'b1, "R10 new prefix acknowledged");
    grp_prefix = 4'b1010; tick(2);

    // R9: repeated start after four wrong bits
    begin
      int p0;
      bus_start();
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      bus_start();
      send_addr(7'b1010101);
      p0 = pulse_cnt;
      send_bit(1'b0);
      ack_clock();
      check(ack_seen == 1'b1, "R9 repeated start restarts address", int'(ack_seen), 1);
      check((pulse_cnt - p0) == 1, "R9 strobe after restart", pulse_cnt - p0, 1);
      bus_stop();
    end

    // R8 / R2: stop mid-address, then a full address without a start
    begin
      int p0;
      bus_start();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      bus_stop();
      scl_m = 1'b0; tick(2);
      p0 = pulse_cnt;
      send_addr(7'b1010101);
      send_bit(1'b0);
      ack_clock();
      check(ack_seen == 1'b0, "R8 stop aborts, R2 no start no acknowledge", int'(ack_seen), 0);
      check((pulse_cnt - p0) == 0, "R2 no strobe without start", pulse_cnt - p0, 0);
      bus_stop();
    end

    // R2: normal transfer still works afterwards
    xfer(7'b1010101, 1'b1, 1'b1, "R2 start after idle accepted");

    tick(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule